// File: doc/BRIEF.md
# Multi-layer pixel overlay compositor

The compositor produces one output pixel stream for a raster whose width and height are programmed. It runs its own column and line counters and, for every position, looks at five layer slots. Each slot holds an enable, a source selector that picks one of five input channels, and a top-left placement. The selected channel supplies the layer's pixel, width and height. Slots stack by number, so slot 4 is on top and slot 0 is at the bottom. A position that no visible layer covers shows a programmed 48-bit ARGB background colour.

An optional colour-key transparency test compares the three low 12-bit colour fields of a pixel against an inclusive min/max range. In source mode, a layer pixel that falls in the range is see-through. In destination mode, a layer is drawn only where the pixel already composited beneath it falls in the range.

Software writes configuration through a simple write port into pending copies. The whole pending set is taken up at the first pixel of a frame, so no frame ever mixes two settings. The output is a valid/ready stream with one register stage. It carries start-of-frame and end-of-line markers. While out_ready is low, the presented pixel and all its markers hold, and the counters do not move.

Top module: `ovl_compositor`

## Requirements
- R1: While rst_n is low, out_valid is 0. In the first cycle after reset, out_valid is 1 and the stream presents pixel (0,0) of a 1x1 raster: background 0, with out_sof and out_eol both set.
- R2: Address 1 sets the raster. Bits [13:0] hold pixels per line minus one, and bits [29:16] hold lines per frame minus one. Pixels leave in raster order. out_sof marks (0,0), out_eol marks the last pixel of each line, and the counters wrap after the last line.
- R3: Once out_valid is 1 it stays 1. While out_ready is 0, out_pix, out_sof and out_eol hold. A pixel is consumed only on a clock edge with out_ready at 1.
- R4: A visible layer covers (x,y) when px <= x < px+width and py <= y < py+height. Width and height come from the selected channel. Any part of a layer beyond the raster is not shown.
- R5: A layer whose enable bit (bit 8 of addresses 8..12) is 0 never contributes. Neither does a layer whose selector code is 5 or higher.
- R6: Selector bits [3:0] of addresses 8+i pick channel 0..4. The layer then shows that channel's pixel. Addresses 16+i hold the position: X in [13:0] and Y in [29:16].
- R7: Where layers overlap, the higher slot number wins.
- R8: The background is {address 3 bits [15:0], address 2 bits [31:0]}.
- R9: The key minimum is {addr 5 [3:0], addr 4} and the key maximum is {addr 7 [3:0], addr 6}. A pixel matches when each of its fields [35:24], [23:12] and [11:0] lies within the bounds, both bounds included. Bits [47:36] are not compared.
- R10: With key enable (addr 0 bit 0) = 1 and key mode (addr 0 bit 1) = 1, a layer pixel that matches is transparent.
- R11: With key enable = 1 and key mode = 0, a layer replaces the pixel composited below it only where that lower pixel matches. The background counts as a lower pixel.
- R12: With key enable = 0, every visible layer is opaque, whatever the key mode.
- R13: A write takes effect from the first pixel of the next frame. The frame in progress, including its own first pixel already presented, keeps its settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 5 | Configuration word address |
| cfg_wr_data | input | 32 | Configuration write data |
| ch_pix | input | 240 | Channel pixels, 48 bits per channel, channel 0 lowest |
| ch_width | input | 70 | Channel widths, 14 bits per channel |
| ch_height | input | 70 | Channel heights, 14 bits per channel |
| out_ready | input | 1 | Downstream accepts the presented pixel |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 48 | Composited ARGB pixel |
| out_sof | output | 1 | Pixel is (0,0) of a frame |
| out_eol | output | 1 | Pixel is the last of its line |

## Verification
The assertions assume that out_ready is a clean 0 or 1 on every edge. They also assume that the raster size the counters see changes only at a frame origin, which the pending-to-active transfer provides. The bench changes configuration only while the stream is stalled after a frame's last pixel has been taken. It holds the channel inputs constant for the whole run and drives out_ready on the falling edge. This makes each presented pixel depend only on the settings of its frame. Every pixel of every frame is compared with an arithmetic model. One frame is checked under the old settings after new ones have been written, to show that the pending copy has no effect until the next frame begins.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int N_LAYERS = 5;
  localparam int PIX_W    = 48;
  localparam int KEY_W    = 36;
  localparam int FLD_W    = 12;
  localparam int CRD_W    = 14;
  localparam int SEL_W    = 4;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int N_FLD    = KEY_W / FLD_W;

  // word addresses of the configuration port
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RASTER = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BG_LO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BG_HI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_KMN_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_KMN_HI = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_KMX_LO = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_KMX_HI = ADDR_W'(7);
  localparam int A_LATTR = 8;
  localparam int A_LPOS  = 16;
  localparam int EN_BIT  = 8;
  localparam int HI_OFS  = 16;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [CRD_W-1:0] px;
    logic [CRD_W-1:0] py;
  } layer_cfg_t;

  typedef struct packed {
    layer_cfg_t [N_LAYERS-1:0] lay;
    logic [CRD_W-1:0]          ppl;
    logic [CRD_W-1:0]          lpf;
    logic [PIX_W-1:0]          bg;
    logic [KEY_W-1:0]          kmin;
    logic [KEY_W-1:0]          kmax;
    logic                      key_en;
    logic                      key_src;
  } cfg_t;

  // every compared colour field must lie inside [lo, hi]
  function automatic logic key_hit(input logic [PIX_W-1:0] p,
                                   input logic [KEY_W-1:0] lo,
                                   input logic [KEY_W-1:0] hi);
    logic ok;
    ok = 1'b1;
    for (int f = 0; f < N_FLD; f++) begin
      if (p[f*FLD_W +: FLD_W] < lo[f*FLD_W +: FLD_W] ||
          p[f*FLD_W +: FLD_W] > hi[f*FLD_W +: FLD_W])
        ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_load,
  input  logic              at_origin,
  output cfg_t              eff
);
  cfg_t pend, act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          pend.key_en  <= wr_data[0];
          pend.key_src <= wr_data[1];
        end
        A_RASTER: begin
          pend.ppl <= wr_data[CRD_W-1:0];
          pend.lpf <= wr_data[HI_OFS +: CRD_W];
        end
        A_BG_LO:  pend.bg[DATA_W-1:0]         <= wr_data;
        A_BG_HI:  pend.bg[PIX_W-1:DATA_W]     <= wr_data[PIX_W-DATA_W-1:0];
        A_KMN_LO: pend.kmin[DATA_W-1:0]       <= wr_data;
        A_KMN_HI: pend.kmin[KEY_W-1:DATA_W]   <= wr_data[KEY_W-DATA_W-1:0];
        A_KMX_LO: pend.kmax[DATA_W-1:0]       <= wr_data;
        A_KMX_HI: pend.kmax[KEY_W-1:DATA_W]   <= wr_data[KEY_W-DATA_W-1:0];
        default: begin
          for (int i = 0; i < N_LAYERS; i++) begin
            if (wr_addr == ADDR_W'(A_LATTR + i)) begin
              pend.lay[i].sel <= wr_data[SEL_W-1:0];
              pend.lay[i].en  <= wr_data[EN_BIT];
            end
            if (wr_addr == ADDR_W'(A_LPOS + i)) begin
              pend.lay[i].px <= wr_data[CRD_W-1:0];
              pend.lay[i].py <= wr_data[HI_OFS +: CRD_W];
            end
          end
        end
      endcase
    end
  end

  // active copy follows the pending copy only when a frame begins
  always_ff @(posedge clk) begin
    if (!rst_n) act <= '0;
    else if (frame_load) act <= pend;
  end

  // the first pixel of a frame already uses the settings it will carry
  assign eff = at_origin ? pend : act;

  // R13: settings in use stay fixed except at a frame origin
  a_r13_frame_settings: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_load && !at_origin) |=> (at_origin || $stable(eff)));
endmodule

// File: rtl/ovl_raster_cnt.sv
module ovl_raster_cnt
  import ovl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CRD_W-1:0] ppl,
  input  logic [CRD_W-1:0] lpf,
  output logic [CRD_W-1:0] x,
  output logic [CRD_W-1:0] y,
  output logic             at_origin,
  output logic             line_end
);
  assign at_origin = (x == '0) && (y == '0);
  assign line_end  = (x == ppl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (adv) begin
      if (line_end) begin
        x <= '0;
        y <= (y == lpf) ? '0 : y + CRD_W'(1);
      end else begin
        x <= x + CRD_W'(1);
      end
    end
  end

  // R2: counters never leave the programmed raster
  a_r2_in_raster: assert property (@(posedge clk) disable iff (!rst_n)
    (x <= ppl) && (y <= lpf));
  // R2: column wraps after the last pixel of a line
  a_r2_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && line_end) |=> (x == '0));
  // R3: position holds without an accept
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(x) && $stable(y)));
endmodule

// File: rtl/ovl_layer_mix.sv
module ovl_layer_mix
  import ovl_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  layer_cfg_t [N_LAYERS-1:0] lay,
  input  logic [PIX_W-1:0]          bg,
  input  logic [KEY_W-1:0]          kmin,
  input  logic [KEY_W-1:0]          kmax,
  input  logic                      key_en,
  input  logic                      key_src,
  input  logic [CRD_W-1:0]          x,
  input  logic [CRD_W-1:0]          y,
  input  logic [NUM_CH*PIX_W-1:0]   ch_pix,
  input  logic [NUM_CH*CRD_W-1:0]   ch_w,
  input  logic [NUM_CH*CRD_W-1:0]   ch_h,
  output logic [PIX_W-1:0]          pix
);
  logic [N_LAYERS-1:0] vis;
  logic [PIX_W-1:0]    lpix [N_LAYERS];

  for (genvar i = 0; i < N_LAYERS; i++) begin : g_lay
    logic [PIX_W-1:0] sp;
    logic [CRD_W-1:0] sw, sh;
    logic             hit;
    logic [CRD_W:0]   xe, ye;

    always_comb begin
      sp  = '0;
      sw  = '0;
      sh  = '0;
      hit = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (lay[i].sel == SEL_W'(c)) begin
          sp  = ch_pix[c*PIX_W +: PIX_W];
          sw  = ch_w[c*CRD_W +: CRD_W];
          sh  = ch_h[c*CRD_W +: CRD_W];
          hit = 1'b1;
        end
      end
    end

    assign xe = {1'b0, lay[i].px} + {1'b0, sw};
    assign ye = {1'b0, lay[i].py} + {1'b0, sh};
    assign vis[i] = lay[i].en && hit &&
                    (x >= lay[i].px) && ({1'b0, x} < xe) &&
                    (y >= lay[i].py) && ({1'b0, y} < ye);
    assign lpix[i] = sp;
  end

  // bottom-up walk: later slots sit on top
  always_comb begin
    logic [PIX_W-1:0] acc;
    acc = bg;
    for (int i = 0; i < N_LAYERS; i++) begin
      if (vis[i]) begin
        if (!key_en)
          acc = lpix[i];
        else if (key_src) begin
          if (!key_hit(lpix[i], kmin, kmax)) acc = lpix[i];
        end else if (key_hit(acc, kmin, kmax))
          acc = lpix[i];
      end
    end
    pix = acc;
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [ADDR_W-1:0]       cfg_wr_addr,
  input  logic [DATA_W-1:0]       cfg_wr_data,
  input  logic [NUM_CH*PIX_W-1:0] ch_pix,
  input  logic [NUM_CH*CRD_W-1:0] ch_width,
  input  logic [NUM_CH*CRD_W-1:0] ch_height,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix,
  output logic                    out_sof,
  output logic                    out_eol
);
  cfg_t             eff;
  logic [CRD_W-1:0] x, y;
  logic             at_origin, line_end, load;
  logic [PIX_W-1:0] mix_pix;

  assign load = !out_valid || out_ready;

  ovl_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_addr    (cfg_wr_addr),
    .wr_data    (cfg_wr_data),
    .frame_load (load && at_origin),
    .at_origin  (at_origin),
    .eff        (eff)
  );

  ovl_raster_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (load),
    .ppl       (eff.ppl),
    .lpf       (eff.lpf),
    .x         (x),
    .y         (y),
    .at_origin (at_origin),
    .line_end  (line_end)
  );

  ovl_layer_mix #(.NUM_CH(NUM_CH)) u_mix (
    .lay     (eff.lay),
    .bg      (eff.bg),
    .kmin    (eff.kmin),
    .kmax    (eff.kmax),
    .key_en  (eff.key_en),
    .key_src (eff.key_src),
    .x       (x),
    .y       (y),
    .ch_pix  (ch_pix),
    .ch_w    (ch_width),
    .ch_h    (ch_height),
    .pix     (mix_pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pix   <= mix_pix;
      out_sof   <= at_origin;
      out_eol   <= line_end;
    end
  end

  // R3: presented pixel holds under back-pressure
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));
  // R3: the stream never withdraws a pixel
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  // R1: the first pixel after reset opens a frame
  a_r1_first_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_sof && out_eol));
endmodule

// File: tb/ovl_compositor_tb.sv
`timescale 1ns/1ps
module ovl_compositor_tb;
  localparam int NL = 5;
  localparam int NC = 5;

  typedef struct {
    logic [13:0] ppl, lpf;
    logic [47:0] bg;
    logic [35:0] kmin, kmax;
    logic        ken, ksrc;
    logic        en  [NL];
    logic [3:0]  sel [NL];
    logic [13:0] px  [NL];
    logic [13:0] py  [NL];
  } tcfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_sof, out_eol;
  logic [47:0] out_pix;
  logic [NC*48-1:0] ch_pix_f;
  logic [NC*14-1:0] ch_w_f, ch_h_f;

  logic [47:0] chp [NC];
  int          chw [NC];
  int          chh [NC];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      ch_pix_f[c*48 +: 48] = chp[c];
      ch_w_f[c*14 +: 14]   = 14'(chw[c]);
      ch_h_f[c*14 +: 14]   = 14'(chh[c]);
    end
  end

  ovl_compositor u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .ch_pix(ch_pix_f), .ch_width(ch_w_f), .ch_height(ch_h_f),
    .out_ready(out_ready), .out_valid(out_valid), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic chk(input string tag, input logic [47:0] a, input logic [47:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, a, e);
    end
  endtask

  function automatic tcfg_t zero_cfg();
    tcfg_t c;
    c.ppl = '0; c.lpf = '0; c.bg = '0; c.kmin = '0; c.kmax = '0;
    c.ken = 1'b0; c.ksrc = 1'b0;
    for (int i = 0; i < NL; i++) begin
      c.en[i] = 1'b0; c.sel[i] = '0; c.px[i] = '0; c.py[i] = '0;
    end
    return c;
  endfunction

  function automatic bit in_key(input tcfg_t c, input logic [47:0] p);
    bit ok = 1'b1;
    for (int f = 0; f < 3; f++) begin
      int v, lo, hi;
      v  = int'((p      >> (12*f)) & 48'hFFF);
      lo = int'((c.kmin >> (12*f)) & 36'hFFF);
      hi = int'((c.kmax >> (12*f)) & 36'hFFF);
      if (v < lo || v > hi) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [47:0] exp_pix(input tcfg_t c, input int x, input int y);
    logic [47:0] acc = c.bg;
    for (int i = 0; i < NL; i++) begin
      int s = int'(c.sel[i]);
      if (c.en[i] && s < NC &&
          x >= int'(c.px[i]) && x < int'(c.px[i]) + chw[s] &&
          y >= int'(c.py[i]) && y < int'(c.py[i]) + chh[s]) begin
        if (!c.ken) acc = chp[s];
        else if (c.ksrc) begin
          if (!in_key(c, chp[s])) acc = chp[s];
        end else if (in_key(c, acc)) acc = chp[s];
      end
    end
    return acc;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 5'(a); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic load_cfg(input tcfg_t c);
    wr(0, {30'b0, c.ksrc, c.ken});
    wr(1, {2'b0, c.lpf, 2'b0, c.ppl});
    wr(2, c.bg[31:0]);
    wr(3, {16'b0, c.bg[47:32]});
    wr(4, c.kmin[31:0]);
    wr(5, {28'b0, c.kmin[35:32]});
    wr(6, c.kmax[31:0]);
    wr(7, {28'b0, c.kmax[35:32]});
    for (int i = 0; i < NL; i++) begin
      wr(8 + i,  {23'b0, c.en[i], 4'b0, c.sel[i]});
      wr(16 + i, {2'b0, c.py[i], 2'b0, c.px[i]});
    end
  endtask

  // consume one whole frame; the stream is left stalled afterwards
  task automatic run_frame(input tcfg_t c, input string tag, input bit stall);
    for (int y = 0; y <= int'(c.lpf); y++) begin
      for (int x = 0; x <= int'(c.ppl); x++) begin
        logic [47:0] e;
        @(negedge clk);
        e = exp_pix(c, x, y);
        chk("R3 valid", {47'b0, out_valid}, 48'd1);
        chk(tag, out_pix, e);
        chk("R2 markers", {46'b0, out_sof, out_eol},
            {46'b0, (x == 0 && y == 0), (x == int'(c.ppl))});
        if (stall && ((x + y) % 3 == 0)) begin
          out_ready = 1'b0;
          repeat (2) @(negedge clk);
          chk("R3 held pixel", out_pix, e);
          chk("R3 held sof", {47'b0, out_sof}, {47'b0, (x == 0 && y == 0)});
        end
        out_ready = 1'b1;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tcfg_t cur, a, b, cc, d, e, f;
    chp[0] = 48'hA00_100_200_300; chw[0] = 3;  chh[0] = 2;
    chp[1] = 48'hB00_555_666_776; chw[1] = 4;  chh[1] = 4;
    chp[2] = 48'hC00_555_666_777; chw[2] = 4;  chh[2] = 3;
    chp[3] = 48'hC00_556_666_777; chw[3] = 2;  chh[3] = 2;
    chp[4] = 48'hE00_0AA_0BB_0CC; chw[4] = 10; chh[4] = 10;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {47'b0, out_valid}, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first valid", {47'b0, out_valid}, 48'd1);
    chk("R1 first pixel", out_pix, 48'd0);
    chk("R1 first markers", {46'b0, out_sof, out_eol}, 48'd3);
    repeat (2) @(negedge clk);
    chk("R3 stall at reset", {47'b0, out_valid}, 48'd1);

    cur = zero_cfg();

    // R2, R8: 8x6 raster, background only
    a = zero_cfg();
    a.ppl = 14'd7; a.lpf = 14'd5; a.bg = 48'h123_456_789_ABC;
    load_cfg(a);
    run_frame(cur, "R13 old 1x1 frame", 1'b0);
    run_frame(a, "R8 background", 1'b0);
    cur = a;

    // R4, R6, R13: placed and clipped layers; old frame checked after the write
    b = a;
    b.en[0] = 1'b1; b.sel[0] = 4'd0; b.px[0] = 14'd2; b.py[0] = 14'd1;
    b.en[3] = 1'b1; b.sel[3] = 4'd4; b.px[3] = 14'd5; b.py[3] = 14'd4;
    load_cfg(b);
    run_frame(cur, "R13 pending ignored", 1'b0);
    run_frame(b, "R4 R6 placement", 1'b0);
    cur = b;

    // R5, R7: overlap priority, disabled and unmapped slots, with back-pressure
    cc = a;
    cc.en[0] = 1'b1; cc.sel[0] = 4'd7; cc.px[0] = 14'd0; cc.py[0] = 14'd0;
    cc.en[1] = 1'b1; cc.sel[1] = 4'd1; cc.px[1] = 14'd0; cc.py[1] = 14'd0;
    cc.en[2] = 1'b1; cc.sel[2] = 4'd2; cc.px[2] = 14'd2; cc.py[2] = 14'd2;
    cc.en[3] = 1'b1; cc.sel[3] = 4'd3; cc.px[3] = 14'd6; cc.py[3] = 14'd0;
    cc.en[4] = 1'b0; cc.sel[4] = 4'd4; cc.px[4] = 14'd0; cc.py[4] = 14'd0;
    load_cfg(cc);
    run_frame(cur, "R13 old layers", 1'b0);
    run_frame(cc, "R5 R7 priority", 1'b1);
    cur = cc;

    // R9, R10: source keying, exact bounds and one field just above max
    d = cc;
    d.ken = 1'b1; d.ksrc = 1'b1;
    d.kmin = 36'h555_666_777; d.kmax = 36'h555_666_777;
    load_cfg(d);
    run_frame(cur, "R7 repeat", 1'b0);
    run_frame(d, "R9 R10 source key", 1'b0);
    cur = d;

    // R11: destination keying against the background
    e = cc;
    e.ken = 1'b1; e.ksrc = 1'b0;
    e.kmin = 36'h456_789_ABC; e.kmax = 36'h456_789_ABC;
    load_cfg(e);
    run_frame(cur, "R10 repeat", 1'b0);
    run_frame(e, "R11 destination key", 1'b0);
    cur = e;

    // R12: key disabled, mode bit set
    f = d;
    f.ken = 1'b0;
    load_cfg(f);
    run_frame(cur, "R11 repeat", 1'b0);
    run_frame(f, "R12 key off", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule